// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel. It copies data from a source address to a destination address through a simple memory-mapped master port. The channel takes its work from descriptors held in memory. Each descriptor is four 32-bit words. The channel reads a descriptor, moves the block of beats that the descriptor defines, and then follows the descriptor's link to the next one. A link of zero ends the transaction. A link that points back to an earlier descriptor forms a circular buffer, which runs until the channel is suspended or disabled.

A transaction starts on one of three triggers: a software strobe, an event strobe or a peripheral request line. Software or an event can pause the channel between beats, and software or an event can resume it. A descriptor can also ask the channel to pause once its block is done. The channel keeps its addresses and beat count while paused, so a resume continues exactly where it stopped. A bus error stops the channel and locks it out until software re-enables it. Three sticky flags report completion, error and suspension. Each flag has its own interrupt enable.

Top module: `dma_chan_engine`

## Requirements
- R1: A trigger accepted in idle makes the channel read four words at `first_desc`, +4, +8 and +12, in that order. Each read has `bus_size`=2. The words are: control, source address, destination address, next-descriptor address. Control word fields: bits [15:0] are the beat count, bits [17:16] the beat size, bit 18 source increment, bit 19 destination increment, bit 20 suspend-after-block.
- R2: Each beat is one read at the source address followed by one write at the destination address. Both accesses carry `bus_size` equal to the beat size (0 = 8-bit, 1 = 16-bit, 2 = 32-bit; 3 behaves as 2). Read data arrives right-aligned on `bus_rdata`. Write data is driven right-aligned on `bus_wdata`, with the bits above the beat size cleared.
- R3: After each beat, an address whose increment bit is set advances by 1, 2 or 4 bytes to match the beat size. An address whose increment bit is clear stays fixed.
- R4: When a block ends and its next-descriptor address is nonzero, the channel fetches that descriptor and carries on. When the address is zero, the channel returns to idle and sets `flag_cmpl`.
- R5: A descriptor whose link points to itself, or to an earlier descriptor, makes the channel repeat its blocks with no further trigger.
- R6: `trig_sel` selects the start source: 0 selects `sw_trig`, 1 selects `evt_trig`, 2 selects `periph_req`, 3 selects none. A strobe on a source that is not selected starts nothing.
- R7: A pulse on `sw_suspend` or `evt_suspend` during a transaction lets the current beat finish. The channel then stops issuing bus requests, asserts `suspended` and sets `flag_susp`. A pulse on `sw_resume` or `evt_resume` continues from the next beat with the addresses and remaining count unchanged.
- R8: When a block ends and its suspend-after bit is set, the channel suspends and sets `flag_susp`. A resume then proceeds to the next descriptor, or to completion if the link is zero.
- R9: A `bus_err` during any access stops the channel, sets `flag_err` and returns it to idle. The channel then ignores triggers until `ch_enable` goes low and back high.
- R10: Each flag stays set until its clear input is pulsed, and a set in the same cycle wins over a clear. `irq` is high exactly when some flag is set whose enable is high. All flags are clear after reset.
- R11: A bus request holds its address, direction and size steady until `bus_ack` or `bus_err` ends it.
- R12: A descriptor with a beat count of zero makes no data access and goes straight to its block-end handling.
- R13: Dropping `ch_enable` returns the channel to idle in the next cycle and removes any bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ch_enable | input | 1 | Channel enable; a rising edge re-arms after an error |
| trig_sel | input | 2 | Start source select |
| sw_trig | input | 1 | Software start strobe |
| evt_trig | input | 1 | Event start strobe |
| periph_req | input | 1 | Peripheral start request |
| sw_suspend | input | 1 | Software suspend strobe |
| sw_resume | input | 1 | Software resume strobe |
| evt_suspend | input | 1 | Event suspend strobe |
| evt_resume | input | 1 | Event resume strobe |
| first_desc | input | AW | Address of the first descriptor |
| ie_cmpl | input | 1 | Interrupt enable for completion |
| ie_err | input | 1 | Interrupt enable for error |
| ie_susp | input | 1 | Interrupt enable for suspend |
| clr_cmpl | input | 1 | Clear completion flag |
| clr_err | input | 1 | Clear error flag |
| clr_susp | input | 1 | Clear suspend flag |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Byte address |
| bus_wdata | output | 32 | Right-aligned write data |
| bus_size | output | 2 | Access size code |
| bus_ack | input | 1 | Access done |
| bus_err | input | 1 | Access failed |
| bus_rdata | input | 32 | Right-aligned read data |
| flag_cmpl | output | 1 | Transaction complete flag |
| flag_err | output | 1 | Channel error flag |
| flag_susp | output | 1 | Channel suspended flag |
| irq | output | 1 | Combined enabled interrupt |
| busy | output | 1 | Channel not idle |
| suspended | output | 1 | Channel halted in suspend |

## Verification
The bench aims at suspends that land while a beat is still waiting for its acknowledge. A design that dropped the pending request, or that advanced its addresses twice, would leave gaps or shifted bytes in the destination once it resumes. It also covers suspend-after blocks, where a design that re-evaluated the flag on resume would stall for good. It checks zero-count descriptors and fixed-address modes at every beat size, where a wrong step or mask corrupts the neighbouring bytes. Last, it tries error lockout and self-linked chains: a design that re-armed itself would restart on the next trigger, and a design that stopped a loop early would fall idle while still enabled.

// File: rtl/dma_chan_engine.sv
`timescale 1ns/1ps
module dma_chan_engine #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ch_enable,
  input  logic [1:0]    trig_sel,
  input  logic          sw_trig,
  input  logic          evt_trig,
  input  logic          periph_req,
  input  logic          sw_suspend,
  input  logic          sw_resume,
  input  logic          evt_suspend,
  input  logic          evt_resume,
  input  logic [AW-1:0] first_desc,
  input  logic          ie_cmpl,
  input  logic          ie_err,
  input  logic          ie_susp,
  input  logic          clr_cmpl,
  input  logic          clr_err,
  input  logic          clr_susp,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  output logic [1:0]    bus_size,
  input  logic          bus_ack,
  input  logic          bus_err,
  input  logic [31:0]   bus_rdata,
  output logic          flag_cmpl,
  output logic          flag_err,
  output logic          flag_susp,
  output logic          irq,
  output logic          busy,
  output logic          suspended
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_WR, S_BEND, S_SUSP} st_t;

  st_t           st, nst;
  logic [1:0]    widx;
  logic [AW-1:0] dptr, src, dst, nxt;
  logic [15:0]   cnt;
  logic [1:0]    bsz;
  logic          sinc, dinc, sflag;
  logic [31:0]   data;
  logic          susp_pend, blk_end, armed, en_q;

  wire trig_hit = (trig_sel == 2'd0 && sw_trig) ||
                  (trig_sel == 2'd1 && evt_trig) ||
                  (trig_sel == 2'd2 && periph_req);
  wire susp_req = sw_suspend | evt_suspend;
  wire res_req  = sw_resume | evt_resume;
  wire hold     = susp_pend | susp_req;
  wire ok_ack   = bus_req & bus_ack & ~bus_err;

  wire [AW-1:0] step = (bsz == 2'd0) ? AW'(1) : (bsz == 2'd1) ? AW'(2) : AW'(4);
  wire [31:0] size_mask = (bsz == 2'd0) ? 32'h0000_00FF :
                          (bsz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;

  assign bus_req   = (st == S_FETCH) || (st == S_RD) || (st == S_WR);
  assign bus_we    = (st == S_WR);
  assign bus_addr  = (st == S_FETCH) ? dptr + AW'({widx, 2'b00}) :
                     (st == S_WR)    ? dst : src;
  assign bus_size  = (st == S_FETCH) ? 2'd2 : bsz;
  assign bus_wdata = data & size_mask;
  assign busy      = (st != S_IDLE);
  assign suspended = (st == S_SUSP);
  assign irq       = (flag_cmpl & ie_cmpl) | (flag_err & ie_err) | (flag_susp & ie_susp);

  always_comb begin
    nst = st;
    case (st)
      S_IDLE:  if (armed && trig_hit) nst = S_FETCH;
      S_FETCH: if (ok_ack && widx == 2'd3)
                 nst = (cnt == 16'd0) ? S_BEND : (hold ? S_SUSP : S_RD);
      S_RD:    if (ok_ack) nst = S_WR;
      S_WR:    if (ok_ack)
                 nst = (cnt == 16'd1) ? S_BEND : (hold ? S_SUSP : S_RD);
      S_BEND:  nst = (sflag && !blk_end) ? S_SUSP :
                     (nxt == '0) ? S_IDLE : S_FETCH;
      S_SUSP:  if (res_req) nst = blk_end ? S_BEND : S_RD;
      default: nst = S_IDLE;
    endcase
    if (bus_req && bus_err) nst = S_IDLE;
    if (!ch_enable) nst = S_IDLE;
  end

  wire set_cmpl = (st == S_BEND) && (nst == S_IDLE) && ch_enable;
  wire set_err  = bus_req && bus_err;
  wire set_susp = (nst == S_SUSP) && (st != S_SUSP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      widx <= '0;
      dptr <= '0;
      src <= '0;
      dst <= '0;
      nxt <= '0;
      cnt <= '0;
      bsz <= '0;
      sinc <= 1'b0;
      dinc <= 1'b0;
      sflag <= 1'b0;
      data <= '0;
      susp_pend <= 1'b0;
      blk_end <= 1'b0;
      armed <= 1'b0;
      en_q <= 1'b0;
      flag_cmpl <= 1'b0;
      flag_err <= 1'b0;
      flag_susp <= 1'b0;
    end else begin
      st <= nst;
      en_q <= ch_enable;
      if (set_err) armed <= 1'b0;
      else if (ch_enable && !en_q) armed <= 1'b1;

      flag_cmpl <= set_cmpl | (flag_cmpl & ~clr_cmpl);
      flag_err  <= set_err  | (flag_err  & ~clr_err);
      flag_susp <= set_susp | (flag_susp & ~clr_susp);

      if (nst == S_IDLE || nst == S_SUSP) susp_pend <= 1'b0;
      else if (susp_req) susp_pend <= 1'b1;

      case (st)
        S_IDLE: if (nst == S_FETCH) begin
          dptr <= first_desc;
          widx <= 2'd0;
          blk_end <= 1'b0;
        end
        S_FETCH: if (ok_ack) begin
          widx <= widx + 2'd1;
          case (widx)
            2'd0: begin
              cnt   <= bus_rdata[15:0];
              bsz   <= (bus_rdata[17:16] == 2'd3) ? 2'd2 : bus_rdata[17:16];
              sinc  <= bus_rdata[18];
              dinc  <= bus_rdata[19];
              sflag <= bus_rdata[20];
            end
            2'd1: src <= bus_rdata[AW-1:0];
            2'd2: dst <= bus_rdata[AW-1:0];
            default: nxt <= bus_rdata[AW-1:0];
          endcase
        end
        S_RD: if (ok_ack) data <= bus_rdata;
        S_WR: if (ok_ack) begin
          cnt <= cnt - 16'd1;
          if (sinc) src <= src + step;
          if (dinc) dst <= dst + step;
        end
        S_BEND: begin
          if (nst == S_SUSP) blk_end <= 1'b1;
          else begin
            blk_end <= 1'b0;
            if (nst == S_FETCH) begin
              dptr <= nxt;
              widx <= 2'd0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !bus_err && ch_enable) |=>
      (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size)));

  // R9
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_err) |=> (!bus_req && flag_err && !busy));

  // R7
  susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !bus_req);

  // R2
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && ok_ack && ch_enable) |=> (bus_req && bus_we));

  // R3
  src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && ok_ack && ch_enable && sinc) |=> (src == $past(src) + $past(step)));

  // R3
  dst_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && ok_ack && ch_enable && !dinc) |=> $stable(dst));

endmodule

// File: tb/dma_chan_engine_tb.sv
`timescale 1ns/1ps
module dma_chan_engine_tb_top;
  localparam int MB = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ch_enable = 0, sw_trig = 0, evt_trig = 0, periph_req = 0;
  logic sw_suspend = 0, sw_resume = 0, evt_suspend = 0, evt_resume = 0;
  logic [1:0] trig_sel = 0;
  logic [31:0] first_desc = 0;
  logic ie_cmpl = 0, ie_err = 0, ie_susp = 0, clr_cmpl = 0, clr_err = 0, clr_susp = 0;
  logic bus_req, bus_we, bus_ack = 0, bus_err = 0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = 0;
  logic [1:0] bus_size;
  logic flag_cmpl, flag_err, flag_susp, irq, busy, suspended;

  always #2.5 clk = ~clk;

  dma_chan_engine #(.AW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .trig_sel(trig_sel),
    .sw_trig(sw_trig), .evt_trig(evt_trig), .periph_req(periph_req),
    .sw_suspend(sw_suspend), .sw_resume(sw_resume), .evt_suspend(evt_suspend),
    .evt_resume(evt_resume), .first_desc(first_desc), .ie_cmpl(ie_cmpl),
    .ie_err(ie_err), .ie_susp(ie_susp), .clr_cmpl(clr_cmpl), .clr_err(clr_err),
    .clr_susp(clr_susp), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_size(bus_size), .bus_ack(bus_ack), .bus_err(bus_err),
    .bus_rdata(bus_rdata), .flag_cmpl(flag_cmpl), .flag_err(flag_err),
    .flag_susp(flag_susp), .irq(irq), .busy(busy), .suspended(suspended));

  logic [7:0] mem [0:MB-1];
  logic [7:0] exp_m [0:MB-1];
  int n_chk = 0, n_bad = 0, wr_cnt = 0, stab_bad = 0, lat = 0, cyc = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic prev_pend = 0;
  logic [31:0] prev_addr = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog run hung actual=%0d expected=0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 0; bus_err = 0; lat = 0; prev_pend = 0;
    end else begin
      if (prev_pend && ch_enable && !(bus_req && bus_addr == prev_addr)) stab_bad++;
      if (bus_ack || bus_err || !bus_req) begin
        bus_ack = 0; bus_err = 0; prev_pend = 0;
      end else if (lat > 0) begin
        lat--; prev_pend = 1; prev_addr = bus_addr;
      end else begin
        prev_pend = 0;
        lat = $urandom_range(2, 0);
        if (bus_addr == err_addr) bus_err = 1;
        else begin
          bus_ack = 1;
          if (bus_we) begin
            for (int i = 0; i < (1 << bus_size); i++)
              mem[(bus_addr + i) % MB] = bus_wdata[8*i +: 8];
            wr_cnt++;
          end else begin
            bus_rdata = 0;
            for (int i = 0; i < (1 << bus_size); i++)
              bus_rdata[8*i +: 8] = mem[(bus_addr + i) % MB];
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr32(input int a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) begin
      mem[(a + i) % MB] = v[8*i +: 8];
      exp_m[(a + i) % MB] = v[8*i +: 8];
    end
  endtask

  function automatic logic [31:0] rd32e(input int a);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) v[8*i +: 8] = exp_m[(a + i) % MB];
    return v;
  endfunction

  task automatic put_desc(input int base, input int cnt, input int bsz, input bit si,
                          input bit di, input bit sf, input int s, input int d, input int nx);
    wr32(base, cnt[15:0] | (bsz << 16) | (32'(si) << 18) | (32'(di) << 19) | (32'(sf) << 20));
    wr32(base + 4, s);
    wr32(base + 8, d);
    wr32(base + 12, nx);
  endtask

  task automatic fill_data();
    for (int a = 16'h100; a < 16'h400; a++) begin
      mem[a] = 8'($urandom);
      exp_m[a] = mem[a];
    end
    for (int a = 16'h400; a < MB; a++) begin
      mem[a] = 0;
      exp_m[a] = 0;
    end
  endtask

  function automatic void model(input int first);
    int p = first;
    for (int n = 0; n < 8 && p != 0; n++) begin
      logic [31:0] c = rd32e(p);
      int s = rd32e(p + 4), d = rd32e(p + 8), nb = 1 << ((c[17:16] == 3) ? 2 : c[17:16]);
      for (int k = 0; k < int'(c[15:0]); k++) begin
        for (int i = 0; i < nb; i++) exp_m[(d + i) % MB] = exp_m[(s + i) % MB];
        if (c[18]) s += nb;
        if (c[19]) d += nb;
      end
      p = rd32e(p + 12);
    end
  endfunction

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int a = 0; a < MB; a++) if (mem[a] !== exp_m[a]) bad++;
    chk(bad == 0, req, "memory bytes differing", bad, 0);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: sw_trig = 1; 1: evt_trig = 1; 2: periph_req = 1;
      3: sw_suspend = 1; 4: evt_suspend = 1; 5: sw_resume = 1; 6: evt_resume = 1;
      7: clr_cmpl = 1; 8: clr_err = 1; default: clr_susp = 1;
    endcase
    tick(1);
    {sw_trig, evt_trig, periph_req, sw_suspend, evt_suspend, sw_resume, evt_resume} = 0;
    {clr_cmpl, clr_err, clr_susp} = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) tick(1);
  endtask

  task automatic wait_susp();
    for (int i = 0; i < 4000 && !suspended; i++) tick(1);
  endtask

  int w0, w1;

  initial begin
    void'($urandom(32'd5150));
    for (int a = 0; a < MB; a++) begin mem[a] = 0; exp_m[a] = 0; end
    tick(8);
    chk(!busy && !bus_req, "R13", "busy/req after reset", busy, 0);
    chk(!flag_cmpl && !flag_err && !flag_susp && !irq, "R10", "flags after reset",
        {flag_cmpl, flag_err, flag_susp, irq}, 0);
    rst_n = 1;
    tick(2);
    ch_enable = 1;
    tick(2);

    // R1 R2 R3 R4: random chains, random sizes and addressing modes
    for (int it = 0; it < 12; it++) begin
      int nd = $urandom_range(3, 1);
      fill_data();
      for (int j = 0; j < nd; j++)
        put_desc(16'h10 + 16'h20 * j, $urandom_range(8, 1), $urandom_range(2, 0),
                 1'($urandom), 1'($urandom), 0, 16'h100 + 16'h100 * j,
                 16'h400 + 16'h100 * j, (j < nd - 1) ? 16'h30 + 16'h20 * j : 0);
      model(16'h10);
      first_desc = 16'h10;
      trig_sel = 2'($urandom_range(2, 0));
      pulse(trig_sel);
      wait_idle();
      cmp_mem("R1 R2 R3 R4");
      chk(flag_cmpl, "R4", "completion flag", flag_cmpl, 1);
      pulse(7);
    end

    // R6: unselected triggers ignored
    fill_data();
    put_desc(16'h10, 2, 2, 1, 1, 0, 16'h100, 16'h400, 0);
    trig_sel = 1;
    w0 = wr_cnt;
    pulse(0); pulse(2);
    tick(10);
    chk(!busy && wr_cnt == w0, "R6", "start on unselected source", wr_cnt - w0, 0);
    pulse(1);
    model(16'h10);
    wait_idle();
    cmp_mem("R6");
    trig_sel = 3;
    pulse(0); pulse(1); pulse(2);
    tick(10);
    chk(!busy, "R6", "busy with no source selected", busy, 0);
    trig_sel = 0;
    pulse(7);

    // R12 R10: zero count, interrupt masking
    w0 = wr_cnt;
    put_desc(16'h10, 0, 2, 1, 1, 0, 16'h100, 16'h400, 0);
    pulse(0);
    wait_idle();
    chk(wr_cnt == w0, "R12", "writes for zero count", wr_cnt - w0, 0);
    chk(flag_cmpl && !irq, "R10", "irq while masked", irq, 0);
    ie_cmpl = 1;
    tick(1);
    chk(irq, "R10", "irq when enabled", irq, 1);
    pulse(7);
    chk(!flag_cmpl && !irq, "R10", "flag after clear", flag_cmpl, 0);
    ie_cmpl = 0;

    // R7: software suspend mid block, resume continues
    fill_data();
    put_desc(16'h10, 8, 2, 1, 1, 0, 16'h100, 16'h400, 0);
    model(16'h10);
    ie_susp = 1;
    w0 = wr_cnt;
    pulse(0);
    for (int i = 0; i < 2000 && wr_cnt < w0 + 3; i++) tick(1);
    pulse(3);
    wait_susp();
    w1 = wr_cnt;
    chk(suspended && flag_susp && irq, "R7", "suspend state/flag/irq",
        {suspended, flag_susp, irq}, 7);
    tick(30);
    chk(wr_cnt == w1 && w1 - w0 < 8, "R7", "writes during suspend", wr_cnt - w1, 0);
    pulse(9);
    chk(!flag_susp && !irq, "R10", "suspend flag after clear", flag_susp, 0);
    pulse(5);
    wait_idle();
    chk(wr_cnt - w0 == 8, "R7", "total beats after resume", wr_cnt - w0, 8);
    cmp_mem("R7");
    ie_susp = 0;
    pulse(7);

    // R8: suspend after block, event resume
    fill_data();
    put_desc(16'h10, 3, 1, 1, 1, 1, 16'h100, 16'h400, 16'h30);
    put_desc(16'h30, 2, 0, 0, 1, 0, 16'h200, 16'h500, 0);
    model(16'h10);
    w0 = wr_cnt;
    pulse(0);
    wait_susp();
    chk(suspended && wr_cnt - w0 == 3, "R8", "beats before self-suspend", wr_cnt - w0, 3);
    chk(flag_susp, "R8", "suspend flag", flag_susp, 1);
    pulse(6);
    wait_idle();
    chk(wr_cnt - w0 == 5 && flag_cmpl, "R8", "beats after resume", wr_cnt - w0, 5);
    cmp_mem("R8");
    pulse(7); pulse(9);

    // R5 R13: circular chain, disable
    put_desc(16'h10, 2, 2, 1, 0, 0, 16'h100, 16'h400, 16'h10);
    w0 = wr_cnt;
    pulse(0);
    tick(200);
    chk(busy && wr_cnt - w0 > 4, "R5", "loop beats", wr_cnt - w0, 5);
    ch_enable = 0;
    tick(2);
    chk(!busy && !bus_req, "R13", "busy after disable", busy, 0);
    w1 = wr_cnt;
    tick(10);
    chk(wr_cnt == w1, "R13", "writes after disable", wr_cnt - w1, 0);
    ch_enable = 1;
    tick(2);

    // R9: bus error lockout and re-arm
    fill_data();
    put_desc(16'h10, 4, 2, 1, 1, 0, 16'h100, 16'h400, 0);
    err_addr = 32'h104;
    ie_err = 1;
    pulse(0);
    wait_idle();
    chk(flag_err && irq && !busy, "R9", "error flag/irq/idle", {flag_err, irq, busy}, 6);
    err_addr = 32'hFFFF_FFFF;
    pulse(0);
    tick(10);
    chk(!busy, "R9", "restart while locked", busy, 0);
    for (int a = 0; a < MB; a++) exp_m[a] = mem[a];
    pulse(8);
    ch_enable = 0; tick(2); ch_enable = 1; tick(2);
    model(16'h10);
    pulse(0);
    wait_idle();
    chk(flag_cmpl && !flag_err, "R9", "run after re-arm", flag_cmpl, 1);
    cmp_mem("R9");

    chk(stab_bad == 0, "R11", "request changes before ack", stab_bad, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule